// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block sits between a serial-bus front end and the register file of a 16750-style UART channel. Each access arrives as a command byte plus a write byte; the block pulls the read flag, the 4-bit register address and the channel number out of the command byte. It then resolves the address to one concrete register. That choice depends on the current line-control value, on the enhanced-function enable bit of the enhanced-feature register, and on the trigger-table enable bit of modem control.

The block itself holds the line-control, enhanced-feature, modem-control, divisor low/high and four flow-character registers. For every other register it emits a write strobe with a select code, the write data and a per-bit write mask. It also emits a read strobe with a select code, and it takes the read value from a flat bus of external read sources. Bits that only exist in enhanced mode are masked while that mode is off, so they keep their old value instead of being cleared.

Accesses use a single `acc_valid` qualifier with no back-pressure: the block accepts every access in the cycle it is presented, and a read always returns one cycle later. Upstream may issue accesses back to back.

Top module: `bankreg_decoder`

## Requirements
- R1: The command byte is split as: bit 7 set means read, bits 6:3 are the register address, and bits 2:1 are the channel, which appears on `chan_o`.
- R2: With line-control bit 7 clear, address 0 reads receive data (code 0) and writes transmit data (code 15), and address 1 reads and writes interrupt enable (code 1).
- R3: With line-control bit 7 set, address 0 accesses the divisor low byte and address 1 the divisor high byte, both held internally and shown on `div_o` as {high, low}. Address 3 always accesses line control, which is shown on `lcr_o`.
- R4: With line control equal to 0xBF, address 2 accesses the enhanced-feature register (`efr_o`). Addresses 4, 5, 6 and 7 access XON1, XON2, XOFF1 and XOFF2, shown on `flow_o` bytes 0 to 3.
- R5: With line control not equal to 0xBF, address 2 reads interrupt identification (code 2) and writes FIFO control (code 16), address 4 is modem control (`mcr_o`), and address 5 reads line status (code 3) and is not writable.
- R6: Outside the 0xBF bank, addresses 6 and 7 select transmission control (code 6) and trigger level (code 7) when both `efr_o` bit 4 and `mcr_o` bit 2 are set. Otherwise they select modem status (code 4, read only) and scratch (code 5).
- R7: While `efr_o` bit 4 is clear, an interrupt-enable write has `wr_bmask_o` = 0x0F and a FIFO-control write has `wr_bmask_o` = 0xCF, and a modem-control write keeps `mcr_o` bits 7:5. While it is set, all masks are 0xFF. Every other external write has mask 0xFF.
- R8: Addresses 8 and 9 read the TX level (code 8) and RX level (code 9) and are not writable. Addresses 10, 11, 12, 14 and 15 read and write GPIO direction, GPIO state, GPIO interrupt enable, I/O control and extra features (codes 10 to 14).
- R9: A write to a read-only location or to address 13 raises no strobe and changes no held register. A read of address 13 returns 0 without a read strobe.
- R10: `wr_en_o`/`wr_sel_o` and `rd_en_o`/`rd_sel_o` are valid in the cycle of the access. A held register shows a write one cycle later. `rd_valid_o` pulses, with `rd_data_o`, exactly one cycle after each read. Reads of held registers return their values without a read strobe.
- R11: After reset all held registers are 0 and `rd_valid_o` is 0.
- R12: Select code k of an external readable register takes its read value from `ext_rdata` bits 8k+7..8k, for k = 0 to 14, using the codes given in R2, R5, R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_cmd | input | 8 | Command byte (read flag, address, channel) |
| acc_wdata | input | 8 | Write data |
| ext_rdata | input | 120 | Read values of the 15 external readable registers |
| chan_o | output | 2 | Channel field of the command |
| wr_en_o | output | 1 | Write strobe to an external register |
| wr_sel_o | output | 5 | Select code of the written register |
| wr_data_o | output | 8 | Write data |
| wr_bmask_o | output | 8 | Per-bit write enable |
| rd_en_o | output | 1 | Read strobe to an external register |
| rd_sel_o | output | 5 | Select code of the read register |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |
| lcr_o | output | 8 | Line control |
| efr_o | output | 8 | Enhanced features |
| mcr_o | output | 8 | Modem control |
| div_o | output | 16 | Divisor {high, low} |
| flow_o | output | 32 | Flow characters XOFF2, XOFF1, XON2, XON1 (high to low) |

## Verification
The assertions check the timing rules of every cycle: each read returns exactly one cycle later and nothing else raises `rd_valid_o`. They also check that a line-control write lands on the next edge, that gated modem-control bits hold while enhanced mode is off, that the interrupt-enable mask is narrowed, and that read-only and reserved addresses never strobe. Only the bench's scenarios can show that the bank map follows the line-control and gate settings. These include moving between the normal, divisor and 0xBF banks, opening the trigger-table gate and reading back every flow character. This is because those results depend on a sequence of earlier writes.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int DW         = 8;
  localparam int AW         = 4;
  localparam int CW         = 2;
  localparam int SELW       = 5;
  localparam int NUM_EXT_RD = 15;
  localparam int NUM_FLOW   = 4;
  localparam logic [DW-1:0] ENH_KEY = 8'hBF;

  typedef enum logic [SELW-1:0] {
    T_RXD   = 5'd0,  T_IEN   = 5'd1,  T_IID   = 5'd2,  T_LSTAT = 5'd3,
    T_MSTAT = 5'd4,  T_SCR   = 5'd5,  T_XCTL  = 5'd6,  T_TLVL  = 5'd7,
    T_TXLVL = 5'd8,  T_RXLVL = 5'd9,  T_IODIR = 5'd10, T_IOST  = 5'd11,
    T_IOIEN = 5'd12, T_IOCTL = 5'd13, T_XFEAT = 5'd14,
    T_TXD   = 5'd15, T_FCTL  = 5'd16,
    T_LCR   = 5'd17, T_FEAT  = 5'd18, T_MCR   = 5'd19, T_DLO   = 5'd20,
    T_DHI   = 5'd21, T_XON1  = 5'd22, T_XON2  = 5'd23, T_XOFF1 = 5'd24,
    T_XOFF2 = 5'd25, T_NONE  = 5'd26
  } tgt_e;

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] addr;
    logic [CW-1:0] chan;
  } cmd_t;
endpackage

// File: rtl/bankreg_cmd_split.sv
module bankreg_cmd_split
  import bankreg_pkg::*;
#(
  parameter int RD_BIT   = 7,
  parameter int ADDR_LSB = 3,
  parameter int CHAN_LSB = 1
) (
  input  logic [DW-1:0] cmd,
  output cmd_t          fld
);
  always_comb begin
    fld.rd   = cmd[RD_BIT];
    fld.addr = cmd[ADDR_LSB +: AW];
    fld.chan = cmd[CHAN_LSB +: CW];
  end
endmodule

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] lcr,
  input  logic          enh_en,
  input  logic          tbl_en,
  output tgt_e          tgt
);
  logic key_bank, div_bank, tbl_open;
  assign key_bank = (lcr == ENH_KEY);
  assign div_bank = lcr[DW-1];
  assign tbl_open = enh_en & tbl_en;

  always_comb begin
    tgt = T_NONE;
    unique case (addr)
      4'd0:  tgt = div_bank ? T_DLO : (rd ? T_RXD : T_TXD);
      4'd1:  tgt = div_bank ? T_DHI : T_IEN;
      4'd2:  tgt = key_bank ? T_FEAT : (rd ? T_IID : T_FCTL);
      4'd3:  tgt = T_LCR;
      4'd4:  tgt = key_bank ? T_XON1 : T_MCR;
      4'd5:  tgt = key_bank ? T_XON2 : (rd ? T_LSTAT : T_NONE);
      4'd6:  tgt = key_bank ? T_XOFF1 : tbl_open ? T_XCTL : (rd ? T_MSTAT : T_NONE);
      4'd7:  tgt = key_bank ? T_XOFF2 : tbl_open ? T_TLVL : T_SCR;
      4'd8:  tgt = rd ? T_TXLVL : T_NONE;
      4'd9:  tgt = rd ? T_RXLVL : T_NONE;
      4'd10: tgt = T_IODIR;
      4'd11: tgt = T_IOST;
      4'd12: tgt = T_IOIEN;
      4'd13: tgt = T_NONE;
      4'd14: tgt = T_IOCTL;
      4'd15: tgt = T_XFEAT;
      default: tgt = T_NONE;
    endcase
  end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
#(
  parameter int MCR_GATE_LSB = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  tgt_e                   tgt,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          lcr,
  output logic [DW-1:0]          efr,
  output logic [DW-1:0]          mcr,
  output logic [DW-1:0]          dll,
  output logic [DW-1:0]          dlh,
  output logic [NUM_FLOW*DW-1:0] flow
);
  localparam logic [DW-1:0] MCR_GATED = {DW{1'b1}} << MCR_GATE_LSB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= '0; efr <= '0; mcr <= '0; dll <= '0; dlh <= '0;
    end else if (wr) begin
      case (tgt)
        T_LCR:  lcr <= wdata;
        T_FEAT: efr <= wdata;
        T_MCR:  mcr <= efr[4] ? wdata : ((mcr & MCR_GATED) | (wdata & ~MCR_GATED));
        T_DLO:  dll <= wdata;
        T_DHI:  dlh <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_FLOW; g++) begin : g_flow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flow[g*DW +: DW] <= '0;
      else if (wr && tgt == tgt_e'(int'(T_XON1) + g))
        flow[g*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/bankreg_decoder.sv
module bankreg_decoder
  import bankreg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic [DW-1:0]            acc_cmd,
  input  logic [DW-1:0]            acc_wdata,
  input  logic [NUM_EXT_RD*DW-1:0] ext_rdata,
  output logic [CW-1:0]            chan_o,
  output logic                     wr_en_o,
  output logic [SELW-1:0]          wr_sel_o,
  output logic [DW-1:0]            wr_data_o,
  output logic [DW-1:0]            wr_bmask_o,
  output logic                     rd_en_o,
  output logic [SELW-1:0]          rd_sel_o,
  output logic                     rd_valid_o,
  output logic [DW-1:0]            rd_data_o,
  output logic [DW-1:0]            lcr_o,
  output logic [DW-1:0]            efr_o,
  output logic [DW-1:0]            mcr_o,
  output logic [2*DW-1:0]          div_o,
  output logic [NUM_FLOW*DW-1:0]   flow_o
);
  cmd_t          fld;
  tgt_e          tgt;
  logic          int_wr;
  logic [DW-1:0] dll, dlh, rd_mux;
  logic [DW-1:0] rd_q;
  logic          rdv_q;

  bankreg_cmd_split u_split (.cmd(acc_cmd), .fld(fld));

  bankreg_map u_map (
    .rd(fld.rd), .addr(fld.addr), .lcr(lcr_o),
    .enh_en(efr_o[4]), .tbl_en(mcr_o[2]), .tgt(tgt)
  );

  assign int_wr = acc_valid && !fld.rd && tgt >= T_LCR && tgt != T_NONE;

  bankreg_store u_store (
    .clk(clk), .rst_n(rst_n), .wr(int_wr), .tgt(tgt), .wdata(acc_wdata),
    .lcr(lcr_o), .efr(efr_o), .mcr(mcr_o), .dll(dll), .dlh(dlh), .flow(flow_o)
  );

  assign chan_o    = fld.chan;
  assign div_o     = {dlh, dll};
  assign wr_en_o   = acc_valid && !fld.rd && tgt < T_LCR;
  assign wr_sel_o  = tgt;
  assign wr_data_o = acc_wdata;
  assign rd_en_o   = acc_valid && fld.rd && tgt < T_TXD;
  assign rd_sel_o  = tgt;

  always_comb begin
    wr_bmask_o = '1;
    if (!efr_o[4]) begin
      if (tgt == T_IEN)  wr_bmask_o = 8'h0F;
      if (tgt == T_FCTL) wr_bmask_o = 8'hCF;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_EXT_RD; k++)
      if (tgt == tgt_e'(k)) rd_mux = ext_rdata[k*DW +: DW];
    case (tgt)
      T_LCR:   rd_mux = lcr_o;
      T_FEAT:  rd_mux = efr_o;
      T_MCR:   rd_mux = mcr_o;
      T_DLO:   rd_mux = dll;
      T_DHI:   rd_mux = dlh;
      T_XON1:  rd_mux = flow_o[0*DW +: DW];
      T_XON2:  rd_mux = flow_o[1*DW +: DW];
      T_XOFF1: rd_mux = flow_o[2*DW +: DW];
      T_XOFF2: rd_mux = flow_o[3*DW +: DW];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      rdv_q <= acc_valid && fld.rd;
      if (acc_valid && fld.rd) rd_q <= rd_mux;
    end
  end

  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rd_q;
endmodule

// File: rtl/bankreg_decoder_chk.sv
module bankreg_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic [7:0] acc_cmd,
  input logic [7:0] acc_wdata,
  input logic       wr_en_o,
  input logic [4:0] wr_sel_o,
  input logic [7:0] wr_bmask_o,
  input logic       rd_en_o,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic [7:0] lcr_o,
  input logic [7:0] efr_o,
  input logic [7:0] mcr_o
);
  logic rd_acc, wr_acc;
  assign rd_acc = acc_valid && acc_cmd[7];
  assign wr_acc = acc_valid && !acc_cmd[7];

  a_r10_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid_o);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid_o);
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && rd_en_o));
  a_r3_lcr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && acc_cmd[6:3] == 4'd3) |=> lcr_o == $past(acc_wdata));
  a_r7_mcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && acc_cmd[6:3] == 4'd4 && lcr_o != 8'hBF && !efr_o[4])
      |=> mcr_o[7:5] == $past(mcr_o[7:5]));
  a_r7_ien_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_sel_o == 5'd1 && !efr_o[4]) |-> wr_bmask_o[7:4] == 4'h0);
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && acc_cmd[6:3] == 4'd13) |=> rd_data_o == 8'h00);
  a_r8_ro_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (acc_cmd[6:3] == 4'd8 || acc_cmd[6:3] == 4'd9 || acc_cmd[6:3] == 4'd13))
      |-> !wr_en_o);
endmodule

bind bankreg_decoder bankreg_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_cmd(acc_cmd),
  .acc_wdata(acc_wdata), .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o),
  .wr_bmask_o(wr_bmask_o), .rd_en_o(rd_en_o), .rd_valid_o(rd_valid_o),
  .rd_data_o(rd_data_o), .lcr_o(lcr_o), .efr_o(efr_o), .mcr_o(mcr_o)
);

// File: tb/bankreg_decoder_tb.sv
module bankreg_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_valid = 1'b0;
  logic [7:0]   acc_cmd = '0;
  logic [7:0]   acc_wdata = '0;
  logic [119:0] ext_rdata;
  logic [1:0]   chan_o;
  logic         wr_en_o, rd_en_o, rd_valid_o;
  logic [4:0]   wr_sel_o, rd_sel_o;
  logic [7:0]   wr_data_o, wr_bmask_o, rd_data_o, lcr_o, efr_o, mcr_o;
  logic [15:0]  div_o;
  logic [31:0]  flow_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_lcr = 0, m_efr = 0, m_mcr = 0, m_dll = 0, m_dlh = 0;
  logic [7:0] m_flow [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  for (genvar k = 0; k < 15; k++) begin : g_ext
    assign ext_rdata[k*8 +: 8] = 8'hA0 + 8'(k);
  end

  bankreg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_cmd(acc_cmd),
    .acc_wdata(acc_wdata), .ext_rdata(ext_rdata), .chan_o(chan_o),
    .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o),
    .wr_bmask_o(wr_bmask_o), .rd_en_o(rd_en_o), .rd_sel_o(rd_sel_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .lcr_o(lcr_o),
    .efr_o(efr_o), .mcr_o(mcr_o), .div_o(div_o), .flow_o(flow_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural target: returns external code, 100+index for held regs, -1 for nothing
  function automatic int ref_target(input bit rd, input int a);
    bit key = (m_lcr == 8'hBF);
    bit dv  = m_lcr[7];
    bit tbl = m_efr[4] && m_mcr[2];
    if (a == 0) return dv ? 103 : (rd ? 0 : 15);
    if (a == 1) return dv ? 104 : 1;
    if (a == 2) return key ? 101 : (rd ? 2 : 16);
    if (a == 3) return 100;
    if (a == 4) return key ? 105 : 102;
    if (a == 5) return key ? 106 : (rd ? 3 : -1);
    if (a == 6) return key ? 107 : tbl ? 6 : (rd ? 4 : -1);
    if (a == 7) return key ? 108 : tbl ? 7 : 5;
    if (a == 8 || a == 9) return rd ? a : -1;
    if (a >= 10 && a <= 12) return a;
    if (a == 14 || a == 15) return a - 1;
    return -1;
  endfunction

  function automatic logic [7:0] held_val(input int t);
    case (t)
      100: return m_lcr;
      101: return m_efr;
      102: return m_mcr;
      103: return m_dll;
      104: return m_dlh;
      default: return m_flow[t-105];
    endcase
  endfunction

  task automatic check_held(input string req);
    chk(req, "lcr_o", lcr_o, m_lcr);
    chk(req, "efr_o", efr_o, m_efr);
    chk(req, "mcr_o", mcr_o, m_mcr);
    chk(req, "div_o", div_o, {m_dlh, m_dll});
    chk(req, "flow_o", flow_o, {m_flow[3], m_flow[2], m_flow[1], m_flow[0]});
  endtask

  // called at a negedge; returns at the next negedge
  task automatic acc(input bit rd, input int a, input logic [7:0] wd, input logic [1:0] ch, input string req);
    int t = ref_target(rd, a);
    bit ext = (t >= 0 && t < 100);
    logic [7:0] expd;
    logic [7:0] expm;
    acc_valid = 1'b1;
    acc_cmd   = {rd, 4'(a), ch, 1'b0};
    acc_wdata = wd;
    #1;
    chk("R1", "chan_o", chan_o, ch);
    chk(req, "wr_en_o", wr_en_o, !rd && ext);
    chk(req, "rd_en_o", rd_en_o, rd && ext && t < 15);
    if (!rd && ext) begin
      expm = 8'hFF;
      if (!m_efr[4] && t == 1)  expm = 8'h0F;
      if (!m_efr[4] && t == 16) expm = 8'hCF;
      chk(req, "wr_sel_o", wr_sel_o, t);
      chk(req, "wr_data_o", wr_data_o, wd);
      chk({req, "/R7"}, "wr_bmask_o", wr_bmask_o, expm);
    end
    if (rd && ext) chk(req, "rd_sel_o", rd_sel_o, t);
    expd = (t < 0) ? 8'h00 : (t < 100) ? 8'hA0 + 8'(t) : held_val(t);
    @(negedge clk);
    acc_valid = 1'b0;
    if (!rd && t >= 100) begin
      case (t)
        100: m_lcr = wd;
        101: m_efr = wd;
        102: m_mcr = m_efr[4] ? wd : {m_mcr[7:5], wd[4:0]};
        103: m_dll = wd;
        104: m_dlh = wd;
        default: m_flow[t-105] = wd;
      endcase
    end
    chk("R10", "rd_valid_o", rd_valid_o, rd);
    if (rd) chk(req, "rd_data_o", rd_data_o, expd);
    check_held(req);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_held("R11");
    chk("R11", "rd_valid_o", rd_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 normal bank
    acc(1, 0, 8'h00, 2'd1, "R2");
    acc(0, 0, 8'h5A, 2'd2, "R2");
    acc(0, 1, 8'hFF, 2'd3, "R2");
    acc(1, 1, 8'h00, 2'd0, "R2");
    // R5 / R7 with gate closed
    acc(0, 2, 8'hFF, 2'd0, "R5");
    acc(1, 2, 8'h00, 2'd0, "R5");
    acc(0, 4, 8'hFF, 2'd1, "R7");
    acc(1, 4, 8'h00, 2'd1, "R5");
    acc(1, 5, 8'h00, 2'd0, "R5");
    acc(0, 5, 8'h77, 2'd0, "R9");
    // R6 closed gate: modem status / scratch
    acc(1, 6, 8'h00, 2'd0, "R6");
    acc(0, 6, 8'h11, 2'd0, "R9");
    acc(0, 7, 8'h22, 2'd0, "R6");
    acc(1, 7, 8'h00, 2'd0, "R6");
    // R3 divisor bank
    acc(0, 3, 8'h80, 2'd0, "R3");
    acc(0, 0, 8'h34, 2'd0, "R3");
    acc(0, 1, 8'h12, 2'd0, "R3");
    acc(1, 0, 8'h00, 2'd0, "R3");
    acc(1, 1, 8'h00, 2'd0, "R3");
    acc(1, 2, 8'h00, 2'd0, "R5");
    // R4 key bank
    acc(0, 3, 8'hBF, 2'd0, "R3");
    acc(0, 2, 8'h10, 2'd0, "R4");
    for (int a = 4; a < 8; a++) acc(0, a, 8'hC0 + 8'(a), 2'(a), "R4");
    for (int a = 2; a < 8; a++) acc(1, a, 8'h00, 2'd0, "R4");
    acc(1, 0, 8'h00, 2'd0, "R3");
    // back to normal bank with gate open
    acc(0, 3, 8'h03, 2'd0, "R3");
    acc(0, 4, 8'hE4, 2'd0, "R7");
    acc(1, 6, 8'h00, 2'd0, "R6");
    acc(0, 6, 8'h33, 2'd0, "R6");
    acc(1, 7, 8'h00, 2'd0, "R6");
    acc(0, 7, 8'h44, 2'd0, "R6");
    acc(0, 1, 8'hF0, 2'd0, "R7");
    acc(0, 2, 8'h30, 2'd0, "R7");
    // R8 / R9 / R12 remaining addresses
    for (int a = 8; a < 16; a++) begin
      acc(1, a, 8'h00, 2'd2, "R8");
      acc(0, a, 8'h5C, 2'd2, "R9");
    end
    for (int a = 0; a < 16; a++) acc(1, a, 8'h00, 2'd3, "R12");
    // close the trigger-table gate again
    acc(0, 4, 8'h00, 2'd0, "R6");
    acc(1, 6, 8'h00, 2'd0, "R6");
    acc(1, 4, 8'h00, 2'd0, "R7");
    repeat (2) @(negedge clk);
    chk("R10", "rd_valid_o idle", rd_valid_o, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule